// File: doc/BRIEF.md
# Set/Reset Offset Calibration Sequencer

This block controls a magnetoresistive bridge sensor that is re-magnetised with short set and reset pulses. During a calibration it drives a set pulse to the external pulse driver and waits for the bridge to settle. It then asks the ADC for one conversion through a start/done handshake. After that it drives a reset pulse, waits again and takes a second conversion. Half the sum of the two readings is stored as the offset term. This term holds the combined DC offset and drift of the bridge and of the analog front end.

Between calibrations no pulses are issued, because the bridge stays in its reset orientation. Each read request triggers one conversion, and the block returns that sample minus the stored offset, marked by a one-cycle valid strobe. A calibration runs on its own after reset and whenever a recalibrate request is pulsed. A programmable interval timer also starts one after a set time spent outside calibration. All pulse widths and delays are parameters counted in clock cycles.

Top module: `mr_offset_cal`

## Requirements
- R1: After reset is released, a calibration starts without any request: `busy_o` is high in the first cycle after the first clock edge with reset low. During reset, all pulse, start, valid and busy outputs are 0 and `offset_o` is 0.
- R2: Each calibration drives `set_pulse_o` high for exactly PULSE_CYC cycles and later drives `reset_pulse_o` high for exactly PULSE_CYC cycles. The set pulse always comes first, and the two outputs are never high in the same cycle.
- R3: After either pulse falls, `adc_start_o` is not asserted until at least SETTLE_CYC cycles have passed.
- R4: The reset pulse rises at least GAP_CYC cycles after the set pulse of the same calibration rose.
- R5: When a calibration ends, `offset_o` holds floor((Vset + Vrst) / 2). Vset is the first sample returned after the set pulse and Vrst is the first sample returned after the reset pulse, both read as two's-complement SAMPLE_W-bit values.
- R6: A read request while idle starts exactly one conversion with no pulse. On its done strobe the block presents `vout_o` = sample − offset as a (SAMPLE_W+1)-bit two's-complement value, with `vout_valid_o` high for one cycle.
- R7: A read request made during a calibration is held and served after the calibration ends, using the new offset. `vout_valid_o` is never high while `busy_o` is high.
- R8: A one-cycle `recal_req` pulse starts a new calibration. `offset_o` does not change while `busy_o` is low.
- R9: With `recal_interval` = N ≠ 0 and no requests, a new calibration begins between N and N+3 cycles after `busy_o` falls. With N = 0, no timed calibration ever starts.
- R10: `adc_start_o` is a single-cycle strobe and is never high while either pulse output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| recal_req | input | 1 | One-cycle request for a new calibration |
| rd_req | input | 1 | One-cycle request for a corrected reading |
| recal_interval | input | TIMER_W | Cycles between timed calibrations, 0 disables the timer |
| adc_start_o | output | 1 | One-cycle conversion start strobe |
| adc_done_i | input | 1 | Conversion done strobe, sample valid with it |
| adc_data_i | input | SAMPLE_W | Signed conversion result |
| set_pulse_o | output | 1 | Set pulse to the bridge pulse driver |
| reset_pulse_o | output | 1 | Reset pulse to the bridge pulse driver |
| busy_o | output | 1 | High while a calibration is in progress |
| offset_o | output | SAMPLE_W | Stored signed offset term |
| vout_o | output | SAMPLE_W+1 | Signed offset-corrected reading |
| vout_valid_o | output | 1 | One-cycle strobe qualifying `vout_o` |

## Verification
The bench builds the block with PULSE_CYC = 3, SETTLE_CYC = 5, GAP_CYC = 20, 12-bit samples and a 16-bit timer. With these values the set pulse, its settling time and the first conversion end before the gap minimum, so the calibration really stalls in the gap wait and R4 is exercised rather than met by accident. Twelve-bit samples let the table reach both ends of full scale, where the corrected result needs its extra bit. Odd negative sums test the floor rounding of the average. An interval of 200 cycles lets the timed recalibration and its disabled setting be observed within a short run.

// File: rtl/mrcal_pkg.sv
package mrcal_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SET,
        ST_SETTLE_S,
        ST_CONV_S,
        ST_GAP,
        ST_RST,
        ST_SETTLE_R,
        ST_CONV_R,
        ST_READ
    } seq_state_e;

    typedef struct packed {
        logic set_drv;
        logic rst_drv;
    } pulse_drv_t;

    // Pulse outputs are a pure decode of the sequencer state.
    function automatic pulse_drv_t drive_for(input seq_state_e st);
        pulse_drv_t d;
        d.set_drv = (st == ST_SET);
        d.rst_drv = (st == ST_RST);
        return d;
    endfunction

    // High while a calibration owns the bridge.
    function automatic logic in_cal(input seq_state_e st);
        return (st != ST_IDLE) && (st != ST_READ);
    endfunction

endpackage

// File: rtl/mrcal_timer.sv
module mrcal_timer #(
    parameter int TIMER_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hold,
    input  logic [TIMER_W-1:0] interval_i,
    output logic               expire_o
);

    logic [TIMER_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            cnt_q    <= '0;
            expire_o <= 1'b0;
        end else begin
            expire_o <= 1'b0;
            if (interval_i != '0) begin
                if (cnt_q == interval_i - TIMER_W'(1)) begin
                    expire_o <= 1'b1;
                    cnt_q    <= '0;
                end else begin
                    cnt_q <= cnt_q + TIMER_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/mrcal_offset.sv
module mrcal_offset #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                cap_set_i,
    input  logic                cap_rst_i,
    input  logic                cap_read_i,
    output logic [SAMPLE_W-1:0] offset_o,
    output logic [SAMPLE_W:0]   corr_o,
    output logic                corr_valid_o
);

    localparam int MSB = SAMPLE_W - 1;

    logic [SAMPLE_W-1:0] vset_q;
    logic [SAMPLE_W:0]   sum_w;
    logic [SAMPLE_W:0]   diff_w;

    // One guard bit for the sum; dropping its LSB is the arithmetic halving.
    assign sum_w  = {vset_q[MSB], vset_q} + {sample_i[MSB], sample_i};
    assign diff_w = {sample_i[MSB], sample_i} - {offset_o[MSB], offset_o};

    always_ff @(posedge clk) begin
        if (rst) begin
            vset_q       <= '0;
            offset_o     <= '0;
            corr_o       <= '0;
            corr_valid_o <= 1'b0;
        end else begin
            corr_valid_o <= 1'b0;
            if (cap_set_i) vset_q <= sample_i;
            if (cap_rst_i) offset_o <= sum_w[SAMPLE_W:1];
            if (cap_read_i) begin
                corr_o       <= diff_w;
                corr_valid_o <= 1'b1;
            end
        end
    end

    // R6: each corrected value is flagged for one cycle only
    a_r6_valid_single: assert property (@(posedge clk) disable iff (rst)
        corr_valid_o |=> !corr_valid_o);

    // R5: the offset only moves on the reset-state capture
    a_r5_offset_on_capture: assert property (@(posedge clk) disable iff (rst)
        !$past(cap_rst_i) && !$past(rst) |-> $stable(offset_o));

endmodule

// File: rtl/mr_offset_cal.sv
module mr_offset_cal #(
    parameter int SAMPLE_W   = 16,
    parameter int TIMER_W    = 32,
    parameter int PULSE_CYC  = 200,
    parameter int SETTLE_CYC = 2000,
    parameter int GAP_CYC    = 2500
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                recal_req,
    input  logic                rd_req,
    input  logic [TIMER_W-1:0]  recal_interval,
    output logic                adc_start_o,
    input  logic                adc_done_i,
    input  logic [SAMPLE_W-1:0] adc_data_i,
    output logic                set_pulse_o,
    output logic                reset_pulse_o,
    output logic                busy_o,
    output logic [SAMPLE_W-1:0] offset_o,
    output logic [SAMPLE_W:0]   vout_o,
    output logic                vout_valid_o
);

    import mrcal_pkg::*;

    localparam int MAXC  = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam int GAP_W = $clog2(GAP_CYC + 1);
    localparam logic [CNT_W-1:0] PULSE_LAST  = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);
    localparam logic [GAP_W-1:0] GAP_LAST    = GAP_W'(GAP_CYC - 1);
    localparam logic [GAP_W-1:0] GAP_SAT     = GAP_W'(GAP_CYC);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [GAP_W-1:0] gap_q;
    logic             cal_pend_q;
    logic             rd_pend_q;
    logic             start_q;
    logic             tmr_expire;
    logic             cal_trig;
    pulse_drv_t       drv;

    assign cal_trig = cal_pend_q | recal_req | tmr_expire;
    assign drv      = drive_for(state_q);

    assign set_pulse_o   = drv.set_drv;
    assign reset_pulse_o = drv.rst_drv;
    assign busy_o        = in_cal(state_q);
    assign adc_start_o   = start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            gap_q      <= '0;
            cal_pend_q <= 1'b1;
            rd_pend_q  <= 1'b0;
            start_q    <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (recal_req || tmr_expire) cal_pend_q <= 1'b1;
            if (rd_req) rd_pend_q <= 1'b1;
            if (gap_q != GAP_SAT) gap_q <= gap_q + GAP_W'(1);
            unique case (state_q)
                ST_IDLE: begin
                    if (cal_trig) begin
                        state_q    <= ST_SET;
                        cnt_q      <= '0;
                        gap_q      <= '0;
                        cal_pend_q <= 1'b0;
                    end else if (rd_pend_q || rd_req) begin
                        state_q   <= ST_READ;
                        start_q   <= 1'b1;
                        rd_pend_q <= 1'b0;
                    end
                end
                ST_SET: begin
                    if (cnt_q == PULSE_LAST) begin
                        state_q <= ST_SETTLE_S;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_SETTLE_S: begin
                    if (cnt_q == SETTLE_LAST) begin
                        state_q <= ST_CONV_S;
                        start_q <= 1'b1;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_CONV_S: begin
                    if (adc_done_i) state_q <= ST_GAP;
                end
                ST_GAP: begin
                    if (gap_q >= GAP_LAST) begin
                        state_q <= ST_RST;
                        cnt_q   <= '0;
                    end
                end
                ST_RST: begin
                    if (cnt_q == PULSE_LAST) begin
                        state_q <= ST_SETTLE_R;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_SETTLE_R: begin
                    if (cnt_q == SETTLE_LAST) begin
                        state_q <= ST_CONV_R;
                        start_q <= 1'b1;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                ST_CONV_R: begin
                    if (adc_done_i) state_q <= ST_IDLE;
                end
                ST_READ: begin
                    if (adc_done_i) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    mrcal_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .hold      (busy_o),
        .interval_i(recal_interval),
        .expire_o  (tmr_expire)
    );

    mrcal_offset #(.SAMPLE_W(SAMPLE_W)) u_offset (
        .clk         (clk),
        .rst         (rst),
        .sample_i    (adc_data_i),
        .cap_set_i   ((state_q == ST_CONV_S) && adc_done_i),
        .cap_rst_i   ((state_q == ST_CONV_R) && adc_done_i),
        .cap_read_i  ((state_q == ST_READ) && adc_done_i),
        .offset_o    (offset_o),
        .corr_o      (vout_o),
        .corr_valid_o(vout_valid_o)
    );

    // R1: calibration begins right after reset without a request
    a_r1_autostart: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |=> busy_o);

    // R2: the two pulse drivers are mutually exclusive
    a_r2_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(set_pulse_o && reset_pulse_o));

    // R10: conversion start is a lone strobe, away from pulses
    a_r10_start_single: assert property (@(posedge clk) disable iff (rst)
        adc_start_o |=> !adc_start_o);
    a_r10_start_quiet: assert property (@(posedge clk) disable iff (rst)
        adc_start_o |-> !set_pulse_o && !reset_pulse_o);

    // R7: no corrected output while calibrating
    a_r7_valid_idle: assert property (@(posedge clk) disable iff (rst)
        vout_valid_o |-> !busy_o);

    // R8: offset frozen outside calibration
    a_r8_offset_hold: assert property (@(posedge clk) disable iff (rst)
        !busy_o && !$past(busy_o) |-> $stable(offset_o));

endmodule

// File: tb/mr_offset_cal_test.sv
module mr_offset_cal_test;

    localparam int SW     = 12;
    localparam int TW     = 16;
    localparam int PULSE  = 3;
    localparam int SETTLE = 5;
    localparam int GAP    = 20;
    localparam int NV     = 6;

    localparam int VS[NV] = '{300, -3, 2047, -2048, 7, -500};
    localparam int VR[NV] = '{100,  0, 2047, -2048, 8,  120};
    localparam int VD[NV] = '{150,  5, -2048, 2047, 7, -1000};

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              recal_req = 1'b0;
    logic              rd_req = 1'b0;
    logic [TW-1:0]     recal_interval = '0;
    logic              adc_start;
    logic              adc_done = 1'b0;
    logic [SW-1:0]     adc_data = '0;
    logic              set_p, rst_p, busy, vvalid;
    logic signed [SW-1:0] offset;
    logic signed [SW:0]   vout;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int cur_vset = 0, cur_vrst = 0, cur_vread = 0;
    int last_pulse = 0;
    int pulse_count = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mr_offset_cal #(
        .SAMPLE_W(SW), .TIMER_W(TW), .PULSE_CYC(PULSE),
        .SETTLE_CYC(SETTLE), .GAP_CYC(GAP)
    ) uut (
        .clk(clk), .rst(rst), .recal_req(recal_req), .rd_req(rd_req),
        .recal_interval(recal_interval), .adc_start_o(adc_start),
        .adc_done_i(adc_done), .adc_data_i(adc_data),
        .set_pulse_o(set_p), .reset_pulse_o(rst_p), .busy_o(busy),
        .offset_o(offset), .vout_o(vout), .vout_valid_o(vvalid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int floor_half(input int a, input int b);
        int s = a + b;
        if (s >= 0) return s / 2;
        return -((-s + 1) / 2);
    endfunction

    // ADC model: answers each start after a few cycles, value chosen by bridge state
    initial begin
        forever begin
            @(negedge clk);
            if (adc_start) begin
                int v;
                if (busy && last_pulse == 1) v = cur_vset;
                else if (busy) v = cur_vrst;
                else v = cur_vread;
                repeat (3) @(negedge clk);
                adc_data = SW'(v);
                adc_done = 1'b1;
                @(negedge clk);
                adc_done = 1'b0;
            end
        end
    end

    // Timing monitor for pulses, settling and strobes
    initial begin
        bit pset = 0, prst = 0, pstart = 0;
        int set_rise = 0, rst_rise = 0, last_fall = -1000;
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst) begin
                if (set_p && rst_p) chk(0, "R2 overlap", 1, 0);
                if (set_p && !pset) begin set_rise = cyc; pulse_count++; end
                if (!set_p && pset) begin
                    chk(cyc - set_rise == PULSE, "R2 set width", cyc - set_rise, PULSE);
                    last_fall = cyc; last_pulse = 1;
                end
                if (rst_p && !prst) begin
                    rst_rise = cyc; pulse_count++;
                    chk(last_pulse == 1, "R2 set before reset", last_pulse, 1);
                    chk(cyc - set_rise >= GAP, "R4 set-to-reset spacing", cyc - set_rise, GAP);
                end
                if (!rst_p && prst) begin
                    chk(cyc - rst_rise == PULSE, "R2 reset width", cyc - rst_rise, PULSE);
                    last_fall = cyc; last_pulse = 2;
                end
                if (adc_start && busy)
                    chk(cyc - last_fall >= SETTLE, "R3 settle", cyc - last_fall, SETTLE);
                if (adc_start && (set_p || rst_p)) chk(0, "R10 start during pulse", 1, 0);
                if (adc_start && pstart) chk(0, "R10 start width", 2, 1);
                if (vvalid && busy) chk(0, "R7 valid while busy", 1, 0);
            end
            pset = set_p; prst = rst_p; pstart = adc_start;
        end
    end

    task automatic wait_cal_done();
        while (!busy) @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic pulse_recal();
        @(negedge clk) recal_req = 1'b1;
        @(negedge clk) recal_req = 1'b0;
    endtask

    task automatic do_read(input int exp, input string req);
        int n = 0;
        int pc = pulse_count;
        @(negedge clk) rd_req = 1'b1;
        @(negedge clk) rd_req = 1'b0;
        while (!vvalid && n < 200) begin @(negedge clk); n++; end
        chk(vvalid == 1'b1, {req, " valid seen"}, vvalid, 1);
        chk(int'(vout) == exp, {req, " corrected value"}, int'(vout), exp);
        @(negedge clk);
        chk(vvalid == 1'b0, "R6 valid one cycle", vvalid, 0);
        chk(pulse_count == pc, "R6 no pulse on read", pulse_count - pc, 0);
    endtask

    initial begin
        int exp_os;
        cur_vset = VS[0]; cur_vrst = VR[0]; cur_vread = VD[0];
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!set_p && !rst_p && !adc_start && !busy && !vvalid, "R1 outputs in reset",
            {set_p, rst_p, adc_start, busy, vvalid}, 0);
        chk(int'(offset) == 0, "R1 offset in reset", int'(offset), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b1, "R1 autostart", busy, 1);
        while (busy) @(negedge clk);

        // Table of calibration and read vectors (R5, R6, R8)
        for (int i = 0; i < NV; i++) begin
            cur_vset = VS[i]; cur_vrst = VR[i]; cur_vread = VD[i];
            if (i != 0) begin
                pulse_recal();
                wait_cal_done();
            end
            exp_os = floor_half(VS[i], VR[i]);
            chk(int'(offset) == exp_os, "R5 offset", int'(offset), exp_os);
            do_read(VD[i] - exp_os, "R6");
            chk(int'(offset) == exp_os, "R8 offset held after read", int'(offset), exp_os);
        end

        // R7: read requested during calibration is deferred, uses new offset
        cur_vset = 40; cur_vrst = -10; cur_vread = 100;
        pulse_recal();
        @(negedge clk);
        chk(busy == 1'b1, "R8 recal starts", busy, 1);
        @(negedge clk) rd_req = 1'b1;
        @(negedge clk) rd_req = 1'b0;
        begin
            int n = 0;
            while (!vvalid && n < 300) begin @(negedge clk); n++; end
            chk(vvalid && !busy, "R7 deferred read served", vvalid, 1);
            chk(int'(vout) == 100 - 15, "R7 deferred value", int'(vout), 85);
        end

        // R9: timed recalibration
        recal_interval = TW'(200);
        pulse_recal();
        wait_cal_done();
        begin
            int n = 0;
            while (!busy && n < 1000) begin @(negedge clk); n++; end
            chk(n >= 200 && n <= 203, "R9 timer interval", n, 200);
        end
        recal_interval = '0;
        while (busy) @(negedge clk);
        begin
            int rises = 0;
            for (int k = 0; k < 1500; k++) begin
                @(negedge clk);
                if (busy) rises++;
            end
            chk(rises == 0, "R9 zero interval disables", rises, 0);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule